// File: doc/BRIEF.md
# Interrupt Arbitration and Stacking Sequencer

This block sits beside a small 8-bit processor core. It decides, at each instruction boundary, whether to take an interrupt, and which one. The candidates are a latched external request, a timer request derived from two timer-control bits, and a software-interrupt opcode. Once a source is accepted, the block runs the bus cycles that save the machine state onto a small stack in internal RAM. It then reads the two-byte service vector for that source and hands a new program counter back to the core, along with a pulse that sets the interrupt mask.

The block also runs the return path. When the core reports a return-from-interrupt opcode at a boundary, the block pops the five saved bytes, restores X, A and the condition codes, and loads the saved program counter. The stack pointer is kept here as a 6-bit wrapping counter, placed beneath fixed upper address bits. The stack therefore always lies in the window 0x0040 to 0x007F.

Top module: `irq_stack_seq`

## Requirements
- R1: A hardware request is accepted only on a clock edge where `instr_done` is high, the block is idle and `i_mask` is 0. With `instr_done` low, nothing is accepted.
- R2: A rising edge on `ext_req` sets an external pending latch. The latch holds while the mask is set, is serviced at the first unmasked boundary, and is cleared when the external interrupt is accepted.
- R3: When the external latch and the timer request are both pending at an unmasked boundary, the external source is taken.
- R4: Stacking writes five bytes in this order: PC[7:0], then {3'b000, PC[12:8]}, then X, then A, then {3'b111, CC[4:0]}. Each byte is written one cycle after the previous one, at a descending stack address.
- R5: The stack address is {7'b0000001, sp}, with a 6-bit `sp` that resets to 0x3F (address 0x007F). `sp` decrements after each push and increments before each pop, and it wraps modulo 64.
- R6: The vector pair is 0x1FFC/0x1FFD for software, 0x1FFA/0x1FFB for external, 0x1FF8/0x1FF9 for timer, and 0x1FF6/0x1FF7 for timer with `wait_mode`=1. The even (high) byte is read first and the odd (low) byte second, one cycle each. The new PC is {high[4:0], low}.
- R7: `mask_set` pulses together with `pc_load` at the end of an interrupt entry. A software interrupt is taken even with `i_mask`=1. `rti_op` and `swi_op` at a boundary take precedence over pending hardware requests, which stay pending.
- R8: The timer request is active only when `tmr_ctl7`=1 and `tmr_ctl6`=0.
- R9: `busy` rises on the edge after acceptance. It stays high for 7 cycles on an entry and 5 cycles on a return, ending with the cycle that carries `pc_load`. Boundaries seen while busy start nothing.
- R10: A return reads CC, A, X, PCH and PCL from ascending stack addresses. On the last read it pulses `pc_load` and `regs_load`, with the restored X, A and CC on the outputs, and it does not pulse `mask_set`.
- R11: After reset `busy` is 0, no memory cycle is driven, and `sp_addr` is 0x007F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_done | input | 1 | Instruction boundary pulse |
| swi_op | input | 1 | Boundary instruction is a software interrupt |
| rti_op | input | 1 | Boundary instruction is a return from interrupt |
| i_mask | input | 1 | Current interrupt mask bit |
| ext_req | input | 1 | External request, edge captured |
| tmr_ctl7 | input | 1 | Timer control bit 7 |
| tmr_ctl6 | input | 1 | Timer control bit 6 |
| wait_mode | input | 1 | Core is in wait mode |
| pc_in | input | 13 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 5 | Condition codes to save |
| mem_addr | output | 13 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe (data same cycle) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Sequence in progress |
| pc_load | output | 1 | Load `pc_new` into PC |
| pc_new | output | 13 | New program counter |
| mask_set | output | 1 | Set the interrupt mask |
| regs_load | output | 1 | Load restored X, A, CC |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 5 | Restored condition codes |
| sp_addr | output | 13 | Current stack pointer address |

## Verification
The bench targets a request that arrives while masked and must survive until the mask clears. A design that dropped such a request would never take it, and one that failed to clear the latch would take the external vector a second time. Simultaneous external and timer requests are checked, as is the wait-mode timer vector; an inverted priority or a wrong vector select shows up as a wrong `pc_new`. Fourteen entries with no return in between drive the stack pointer through 0x0040 and back to 0x007F, where a pointer that saturated or leaked into the upper bits would write outside the window. Boundaries held high throughout a busy sequence expose any re-arbitration as extra writes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int SP_W   = 6;
    localparam int CC_W   = 5;
    localparam int CNT_W  = 3;
    localparam int NBYTES = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_POP
    } seq_st_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_RTI, SRC_SWI, SRC_EXT, SRC_TMR
    } src_e;
endpackage

// File: rtl/ext_req_latch.sv
module ext_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } lat_t;

    lat_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.prev = req_in;
        l_d.pend = (l_q.pend & ~clr) | (req_in & ~l_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign pend = l_q.pend;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_seq_pkg::*;
(
    input  logic idle,
    input  logic instr_done,
    input  logic rti_op,
    input  logic swi_op,
    input  logic i_mask,
    input  logic ext_pend,
    input  logic tmr_pend,
    output src_e src
);
    always_comb begin
        src = SRC_NONE;
        if (idle && instr_done) begin
            if (rti_op)                     src = SRC_RTI;
            else if (swi_op)                src = SRC_SWI;
            else if (!i_mask && ext_pend)   src = SRC_EXT;
            else if (!i_mask && tmr_pend)   src = SRC_TMR;
        end
    end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_SWI      = 13'h1FFC,
    parameter logic [ADDR_W-1:0] VEC_EXT      = 13'h1FFA,
    parameter logic [ADDR_W-1:0] VEC_TMR      = 13'h1FF8,
    parameter logic [ADDR_W-1:0] VEC_TMR_WAIT = 13'h1FF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              swi_op,
    input  logic              rti_op,
    input  logic              i_mask,
    input  logic              ext_req,
    input  logic              tmr_ctl7,
    input  logic              tmr_ctl6,
    input  logic              wait_mode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] a_in,
    input  logic [CC_W-1:0]   cc_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_new,
    output logic              mask_set,
    output logic              regs_load,
    output logic [DATA_W-1:0] x_out,
    output logic [DATA_W-1:0] a_out,
    output logic [CC_W-1:0]   cc_out,
    output logic [ADDR_W-1:0] sp_addr
);
    localparam int HI_W = ADDR_W - SP_W;
    localparam int PCH_W = ADDR_W - DATA_W;
    localparam logic [HI_W-1:0]  STK_HI  = HI_W'(1);
    localparam logic [SP_W-1:0]  SP_TOP  = '1;
    localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(NBYTES - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [SP_W-1:0]   sp;
        logic [ADDR_W-1:0] vec;
        logic [DATA_W-1:0] b_pcl;
        logic [DATA_W-1:0] b_pch;
        logic [DATA_W-1:0] b_x;
        logic [DATA_W-1:0] b_a;
        logic [DATA_W-1:0] b_cc;
    } seq_t;

    seq_t r_d, r_q;
    src_e src;
    logic ext_pend;
    logic tmr_pend;
    logic [SP_W-1:0] sp_up;

    assign tmr_pend = tmr_ctl7 & ~tmr_ctl6;

    ext_req_latch u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (ext_req),
        .clr    (src == SRC_EXT),
        .pend   (ext_pend)
    );

    irq_arb u_arb (
        .idle       (r_q.st == ST_IDLE),
        .instr_done (instr_done),
        .rti_op     (rti_op),
        .swi_op     (swi_op),
        .i_mask     (i_mask),
        .ext_pend   (ext_pend),
        .tmr_pend   (tmr_pend),
        .src        (src)
    );

    assign sp_up = r_q.sp + SP_W'(1);

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        pc_new    = '0;
        mask_set  = 1'b0;
        regs_load = 1'b0;
        x_out     = r_q.b_x;
        a_out     = r_q.b_a;
        cc_out    = r_q.b_cc[CC_W-1:0];

        case (r_q.st)
            ST_IDLE: begin
                if (src != SRC_NONE) begin
                    r_d.cnt   = '0;
                    r_d.b_pcl = pc_in[DATA_W-1:0];
                    r_d.b_pch = {{(DATA_W-PCH_W){1'b0}}, pc_in[ADDR_W-1:DATA_W]};
                    r_d.b_x   = x_in;
                    r_d.b_a   = a_in;
                    r_d.b_cc  = {{(DATA_W-CC_W){1'b1}}, cc_in};
                    r_d.st    = (src == SRC_RTI) ? ST_POP : ST_PUSH;
                    case (src)
                        SRC_SWI: r_d.vec = VEC_SWI;
                        SRC_EXT: r_d.vec = VEC_EXT;
                        SRC_TMR: r_d.vec = wait_mode ? VEC_TMR_WAIT : VEC_TMR;
                        default: r_d.vec = r_q.vec;
                    endcase
                end
            end
            ST_PUSH: begin
                mem_we   = 1'b1;
                mem_addr = {STK_HI, r_q.sp};
                case (r_q.cnt)
                    3'd0:    mem_wdata = r_q.b_pcl;
                    3'd1:    mem_wdata = r_q.b_pch;
                    3'd2:    mem_wdata = r_q.b_x;
                    3'd3:    mem_wdata = r_q.b_a;
                    default: mem_wdata = r_q.b_cc;
                endcase
                r_d.sp  = r_q.sp - SP_W'(1);
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == LAST_IX) r_d.st = ST_VHI;
            end
            ST_VHI: begin
                mem_re    = 1'b1;
                mem_addr  = r_q.vec;
                r_d.b_pch = mem_rdata;
                r_d.st    = ST_VLO;
            end
            ST_VLO: begin
                mem_re   = 1'b1;
                mem_addr = r_q.vec + ADDR_W'(1);
                pc_load  = 1'b1;
                pc_new   = {r_q.b_pch[PCH_W-1:0], mem_rdata};
                mask_set = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_POP: begin
                mem_re   = 1'b1;
                mem_addr = {STK_HI, sp_up};
                r_d.sp   = sp_up;
                r_d.cnt  = r_q.cnt + CNT_W'(1);
                case (r_q.cnt)
                    3'd0: r_d.b_cc  = mem_rdata;
                    3'd1: r_d.b_a   = mem_rdata;
                    3'd2: r_d.b_x   = mem_rdata;
                    3'd3: r_d.b_pch = mem_rdata;
                    default: begin
                        pc_load   = 1'b1;
                        regs_load = 1'b1;
                        pc_new    = {r_q.b_pch[PCH_W-1:0], mem_rdata};
                        r_d.st    = ST_IDLE;
                    end
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.sp <= SP_TOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign sp_addr = {STK_HI, r_q.sp};
endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_done,
    input logic [12:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        busy,
    input logic        pc_load,
    input logic        mask_set,
    input logic        regs_load
);
    assert_stack_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[12:6] == 7'b0000001);

    assert_push_descend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr[5:0] == $past(mem_addr[5:0]) - 6'd1);

    assert_pop_ascend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re) && mem_addr[12:6] == 7'd1 && $past(mem_addr[12:6]) == 7'd1)
        |-> mem_addr[5:0] == $past(mem_addr[5:0]) + 6'd1);

    assert_vector_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr[12:4] == 9'h1FF && !mem_addr[0])
        |=> (mem_re && mem_addr == $past(mem_addr) + 13'd1));

    assert_load_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> busy);

    assert_accept_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_done));

    assert_mask_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |-> (pc_load && !regs_load));

    assert_no_mixed_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

bind irq_stack_seq irq_stack_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .busy       (busy),
    .pc_load    (pc_load),
    .mask_set   (mask_set),
    .regs_load  (regs_load)
);

// File: tb/irq_stack_seq_tb_top.sv
module irq_stack_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 0, swi_op = 0, rti_op = 0, i_mask = 0;
    logic        ext_req = 0, tmr_ctl7 = 0, tmr_ctl6 = 0, wait_mode = 0;
    logic [12:0] pc_in = '0;
    logic [7:0]  x_in = '0, a_in = '0;
    logic [4:0]  cc_in = '0;
    logic [12:0] mem_addr, pc_new, sp_addr;
    logic        mem_we, mem_re, busy, pc_load, mask_set, regs_load;
    logic [7:0]  mem_wdata, mem_rdata, x_out, a_out;
    logic [4:0]  cc_out;

    always #4 clk = ~clk;

    irq_stack_seq dut_i (.*);

    logic [7:0] stk [64];
    function automatic logic [7:0] vdat(input logic [12:0] ad);
        return ad[7:0] * 8'd37 + 8'h11;
    endfunction
    always_comb mem_rdata = (mem_addr[12:6] == 7'd1) ? stk[mem_addr[5:0]] : vdat(mem_addr);

    int nwr, nrd, nload, nbusy;
    logic [12:0] wa [16];
    logic [7:0]  wd [16];
    logic [12:0] ra [16];
    logic [12:0] g_pc;
    logic        g_ms, g_rl;
    logic [7:0]  g_x, g_a;
    logic [4:0]  g_cc;

    always @(posedge clk) begin
        if (mem_we) begin
            stk[mem_addr[5:0]] = mem_wdata;
            if (nwr < 16) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; end
            nwr++;
        end
        if (mem_re) begin
            if (nrd < 16) ra[nrd] = mem_addr;
            nrd++;
        end
        if (pc_load) begin
            nload++; g_pc = pc_new; g_ms = mask_set; g_rl = regs_load;
            g_x = x_out; g_a = a_out; g_cc = cc_out;
        end
    end

    int checks = 0, errors = 0;
    bit done = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [5:0] exp_sp = 6'h3F;
    bit         exp_ext = 0;

    task automatic pulse_ext();
        @(negedge clk); ext_req = 1;
        @(negedge clk); ext_req = 0;
        exp_ext = 1;
    endtask

    // kind: 0 none, 1 return, 2 software, 3 external, 4 timer
    task automatic boundary(input bit rti, input bit swi, input bit msk, input bit wt,
                            input bit t7, input bit t6, input bit hold, input string req);
        int kind;
        logic [12:0] v, epc;
        logic [7:0] ebyte [5];
        logic [7:0] rb [5];
        kind = rti ? 1 : swi ? 2 : (!msk && exp_ext) ? 3 : (!msk && t7 && !t6) ? 4 : 0;
        v = (kind == 2) ? 13'h1FFC : (kind == 3) ? 13'h1FFA :
            (wt ? 13'h1FF6 : 13'h1FF8);
        ebyte[0] = pc_in[7:0]; ebyte[1] = {3'b000, pc_in[12:8]};
        ebyte[2] = x_in; ebyte[3] = a_in; ebyte[4] = {3'b111, cc_in};
        for (int k = 0; k < 5; k++) rb[k] = stk[6'(exp_sp + 6'(k + 1))];
        nwr = 0; nrd = 0; nload = 0; nbusy = 0;
        rti_op = rti; swi_op = swi; i_mask = msk; wait_mode = wt;
        tmr_ctl7 = t7; tmr_ctl6 = t6; instr_done = 1;
        @(negedge clk);
        if (!hold) begin instr_done = 0; rti_op = 0; swi_op = 0; end
        for (int g = 0; g < 40 && busy; g++) begin nbusy++; @(negedge clk); end
        instr_done = 0; rti_op = 0; swi_op = 0;
        @(negedge clk);
        if (kind == 0) begin
            chk(nwr == 0 && nload == 0 && nbusy == 0, req, "no action", nwr + nload, 0);
        end else if (kind == 1) begin
            epc = {rb[3][4:0], rb[4]};
            chk(nwr == 0 && nrd == 5 && nbusy == 5, "R10", "pop cycles", nrd, 5);
            chk(nload == 1 && g_rl && !g_ms, "R10", "load pulses", {g_rl, g_ms}, 2);
            chk(g_pc == epc, "R10", "restored pc", g_pc, epc);
            chk({g_x, g_a, g_cc} == {rb[2], rb[1], rb[0][4:0]}, "R10", "restored regs",
                {g_x, g_a, g_cc}, {rb[2], rb[1], rb[0][4:0]});
            exp_sp = exp_sp + 6'd5;
        end else begin
            bit ok = (nwr == 5);
            for (int k = 0; k < 5; k++)
                if (wa[k] != {7'd1, 6'(exp_sp - 6'(k))} || wd[k] != ebyte[k]) ok = 0;
            chk(ok, "R4", "push sequence", nwr, 5);
            chk(nrd == 2 && ra[0] == v && ra[1] == v + 13'd1, "R6", "vector reads", ra[0], v);
            epc = {vdat(v)[4:0], vdat(v + 13'd1)};
            chk(nload == 1 && g_pc == epc, req, "vector pc", g_pc, epc);
            chk(g_ms && !g_rl, "R7", "mask set at entry", {g_ms, g_rl}, 2);
            chk(nbusy == 7, "R9", "busy length", nbusy, 7);
            exp_sp = exp_sp - 6'd5;
            if (kind == 3) exp_ext = 0;
        end
        chk(sp_addr == {7'd1, exp_sp}, "R5", "stack pointer", sp_addr, {7'd1, exp_sp});
    endtask

    task automatic set_state(input logic [12:0] p, input logic [7:0] x, input logic [7:0] a,
                             input logic [4:0] c);
        pc_in = p; x_in = x; a_in = a; cc_in = c;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we && !mem_re && sp_addr == 13'h007F, "R11", "reset state", sp_addr, 13'h7F);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_we && !mem_re && sp_addr == 13'h007F, "R11", "after reset", sp_addr, 13'h7F);

        set_state(13'h1234, 8'hA5, 8'h3C, 5'h15);
        boundary(0, 0, 0, 0, 1, 1, 0, "R8");
        boundary(0, 0, 0, 0, 0, 0, 0, "R8");
        boundary(0, 0, 0, 0, 1, 0, 0, "R8");
        boundary(1, 0, 1, 0, 0, 0, 0, "R10");

        pulse_ext();
        i_mask = 0;
        repeat (4) @(negedge clk);
        chk(!busy && nwr == 0, "R1", "no take without boundary", busy, 0);
        boundary(0, 0, 1, 0, 0, 0, 0, "R2");
        boundary(0, 0, 0, 0, 0, 0, 0, "R2");
        boundary(0, 0, 0, 0, 0, 0, 0, "R2");

        pulse_ext();
        set_state(13'h0F0E, 8'h11, 8'h22, 5'h1F);
        boundary(0, 0, 0, 0, 1, 0, 0, "R3");
        boundary(0, 0, 0, 1, 1, 0, 0, "R6");
        pulse_ext();
        boundary(0, 1, 1, 0, 1, 0, 0, "R7");
        boundary(0, 0, 0, 0, 0, 0, 0, "R7");
        boundary(1, 0, 1, 0, 0, 0, 0, "R10");
        boundary(1, 0, 1, 0, 0, 0, 0, "R10");
        boundary(1, 0, 1, 0, 0, 0, 0, "R10");

        set_state(13'h1ABC, 8'h5A, 8'hC3, 5'h0A);
        boundary(0, 1, 0, 0, 0, 0, 1, "R9");

        for (int i = 0; i < 14; i++) begin
            set_state(13'($urandom), 8'($urandom), 8'($urandom), 5'($urandom));
            boundary(0, 1, 1, 0, 0, 0, 0, "R5");
        end
        for (int i = 0; i < 3; i++) boundary(1, 0, 1, 0, 0, 0, 0, "R10");

        for (int i = 0; i < 60; i++) begin
            int r = $urandom % 8;
            set_state(13'($urandom), 8'($urandom), 8'($urandom), 5'($urandom));
            if (r == 0) pulse_ext();
            boundary(r == 7, r == 6, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), "R6");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule